// File: doc/BRIEF.md
# Prioritised vectored interrupt controller

The controller gathers 32 level-sensitive interrupt requests into a single IRQ line for a processor. Software enables sources one by one through a pair of set and clear registers, sees the enabled and active sources in a status register, and binds up to 16 sources to numbered slots. Each slot holds a source number, an enable flag and a 32-bit address word. Slot 0 has the highest priority and slot 15 the lowest.

A read of the vector register returns the address word of the highest-priority slot that is currently requesting. If no slot is requesting, it returns a default word that software programs. Software can use the default word, for example all ones, as a marker for non-vectored handling, and then pick the lowest set bit of the status register itself.

A vector read that returns a slot puts that slot's priority level in service. From then on, that slot and every lower-priority slot are held off. Any write to the vector register retires the most recent level in service, so higher-priority slots can nest over lower ones.

Top module: `vic_top`

## Requirements
- R1: After reset the enable mask, the status register, every slot control word, every slot address word and the default word read as zero, and `irq` is low.
- R2: A write to the enable register (offset 0x004) sets every enable bit whose data bit is 1 and leaves the other enable bits unchanged. A read of offset 0x004 returns the enable mask.
- R3: A write to the enable-clear register (offset 0x008) clears every enable bit whose data bit is 1 and leaves the other enable bits unchanged.
- R4: The status register (offset 0x000) reads as the bitwise AND of `irqReq` and the enable mask, in the same cycle. `irq` is high exactly when that AND is non-zero.
- R5: The slot n address word is at 0x100 + 4n and the slot n control word is at 0x200 + 4n. In the control word, bits 4:0 hold the source number and bit 5 is the slot enable. A control read returns those 6 bits, with all higher bits zero.
- R6: A read of the vector register (offset 0x00C) returns the address word of the lowest-numbered eligible slot. A slot is eligible when its enable bit is 1, its source is set in the status register, and it is not held off.
- R7: When no slot is eligible, a vector read returns the default word (offset 0x010), which reads back as written.
- R8: A slot whose source is clear in the enable mask never wins, even while its request input is high.
- R9: A vector read that returns slot k holds off slots k through 15 until that level is retired. Slots below k can still win.
- R10: Any write to the vector register retires the most recently entered level in service, whatever the data. With no level in service, the write changes nothing.
- R11: Levels nest. After a preempting slot's level is retired, the earlier, lower-priority level is still in service.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| irqReq | input | 32 | Level request per source, active high |
| regWrEn | input | 1 | Register write strobe |
| regRdEn | input | 1 | Register read strobe (a vector read has a side effect) |
| regAddr | input | 12 | Byte address of the register |
| regWrData | input | 32 | Write data |
| regRdData | output | 32 | Read data, valid in the cycle of the read strobe |
| irq | output | 1 | Interrupt request to the processor |

## Verification
The two functions that can meet in one cycle are retiring a level in service and a new higher-priority request arriving. The bench writes the vector register in the same cycle that it raises the request of a more urgent slot, while a less urgent slot is in service. It then checks that the next vector read returns the new slot's address and not the default word. The nesting checks also read the vector register while a level is held off. They confirm that the default word comes back, and that the earlier level survives the retirement of the preempting one.

// File: rtl/vic_pkg.sv
package vic_pkg;

  // Register byte offsets
  localparam int unsigned OFS_STATUS  = 'h000;
  localparam int unsigned OFS_ENABLE  = 'h004;
  localparam int unsigned OFS_ENCLR   = 'h008;
  localparam int unsigned OFS_VECTOR  = 'h00C;
  localparam int unsigned OFS_DEFAULT = 'h010;
  // Page numbers (address bits above 7) of the per-slot register banks
  localparam int unsigned PAGE_SLOTADDR = 1;
  localparam int unsigned PAGE_SLOTCTL  = 2;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_STATUS,
    SEL_ENABLE,
    SEL_ENCLR,
    SEL_VECTOR,
    SEL_DEFAULT,
    SEL_SLOTADDR,
    SEL_SLOTCTL
  } rdSel_e;

  // Strobes from the control module to the datapath
  typedef struct packed {
    logic enSet;
    logic enClr;
    logic defWr;
    logic slotAddrWr;
    logic slotCtlWr;
    logic vecRead;
    logic vecAck;
  } strobes_t;

endpackage

// File: rtl/vic_ctrl.sv
module vic_ctrl
  import vic_pkg::*;
#(
  parameter int NUM_SLOT = 16,
  parameter int ADDR_W   = 12,
  localparam int SLOT_W  = $clog2(NUM_SLOT)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                regWrEn,
  input  logic                regRdEn,
  input  logic [ADDR_W-1:0]   regAddr,
  input  logic                winValid,
  input  logic [SLOT_W-1:0]   winIdx,
  output strobes_t            stb,
  output rdSel_e              rdSel,
  output logic [SLOT_W-1:0]   slotIdx,
  output logic [NUM_SLOT-1:0] allowMask
);

  localparam logic [NUM_SLOT-1:0] ONE = NUM_SLOT'(1);

  logic [ADDR_W-9:0]   page;
  logic [7:0]          off;
  logic                slotHit;
  logic [NUM_SLOT-1:0] inSvc, inSvcNext, lowBit;

  assign page    = regAddr[ADDR_W-1:8];
  assign off     = regAddr[7:0];
  assign slotHit = (off[1:0] == 2'b00) && (int'(off[7:2]) < NUM_SLOT);
  assign slotIdx = off[2 +: SLOT_W];

  // Address decode
  always_comb begin
    rdSel = SEL_NONE;
    if (regAddr == ADDR_W'(OFS_STATUS))       rdSel = SEL_STATUS;
    else if (regAddr == ADDR_W'(OFS_ENABLE))  rdSel = SEL_ENABLE;
    else if (regAddr == ADDR_W'(OFS_ENCLR))   rdSel = SEL_ENCLR;
    else if (regAddr == ADDR_W'(OFS_VECTOR))  rdSel = SEL_VECTOR;
    else if (regAddr == ADDR_W'(OFS_DEFAULT)) rdSel = SEL_DEFAULT;
    else if (int'(page) == PAGE_SLOTADDR && slotHit) rdSel = SEL_SLOTADDR;
    else if (int'(page) == PAGE_SLOTCTL && slotHit)  rdSel = SEL_SLOTCTL;
  end

  always_comb begin
    stb.enSet      = regWrEn && (rdSel == SEL_ENABLE);
    stb.enClr      = regWrEn && (rdSel == SEL_ENCLR);
    stb.defWr      = regWrEn && (rdSel == SEL_DEFAULT);
    stb.slotAddrWr = regWrEn && (rdSel == SEL_SLOTADDR);
    stb.slotCtlWr  = regWrEn && (rdSel == SEL_SLOTCTL);
    stb.vecAck     = regWrEn && (rdSel == SEL_VECTOR);
    stb.vecRead    = regRdEn && (rdSel == SEL_VECTOR);
  end

  // In-service levels: one bit per slot, the lowest set bit is the active level
  assign lowBit    = inSvc & (~inSvc + ONE);
  assign allowMask = (inSvc == '0) ? '1 : (lowBit - ONE);

  always_comb begin
    inSvcNext = inSvc;
    if (stb.vecAck) inSvcNext = inSvcNext & (inSvcNext - ONE);
    if (stb.vecRead && winValid) inSvcNext[winIdx] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) inSvc <= '0;
    else       inSvc <= inSvcNext;
  end

  // R9: a returned slot enters service
  p_push_level_r9: assert property (@(posedge clk) disable iff (!rstN)
    (stb.vecRead && !stb.vecAck && winValid) |=> inSvc[$past(winIdx)]);

  // R10: acknowledge retires exactly one level
  p_ack_pops_r10: assert property (@(posedge clk) disable iff (!rstN)
    (stb.vecAck && !stb.vecRead && inSvc != '0)
      |=> $countones(inSvc) == $countones($past(inSvc)) - 1);

  // R10: acknowledge with nothing in service is harmless
  p_ack_idle_r10: assert property (@(posedge clk) disable iff (!rstN)
    (stb.vecAck && !stb.vecRead && inSvc == '0) |=> inSvc == '0);

endmodule

// File: rtl/vic_datapath.sv
module vic_datapath
  import vic_pkg::*;
#(
  parameter int NUM_SRC  = 32,
  parameter int NUM_SLOT = 16,
  parameter int DATA_W   = 32,
  localparam int SLOT_W  = $clog2(NUM_SLOT),
  localparam int SRC_W   = $clog2(NUM_SRC)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [NUM_SRC-1:0]  irqReq,
  input  strobes_t            stb,
  input  rdSel_e              rdSel,
  input  logic [SLOT_W-1:0]   slotIdx,
  input  logic [DATA_W-1:0]   wrData,
  input  logic [NUM_SLOT-1:0] allowMask,
  output logic                winValid,
  output logic [SLOT_W-1:0]   winIdx,
  output logic [DATA_W-1:0]   rdData,
  output logic                irq
);

  logic [NUM_SRC-1:0]  enableMask;
  logic [NUM_SRC-1:0]  status;
  logic [DATA_W-1:0]   defaultAddr;
  logic [DATA_W-1:0]   slotAddr [NUM_SLOT];
  logic [SRC_W-1:0]    slotSrc  [NUM_SLOT];
  logic                slotEn   [NUM_SLOT];
  logic [NUM_SLOT-1:0] candidate;
  logic                unusedStb;

  assign unusedStb = ^{stb.vecRead, stb.vecAck};

  // Enable mask and default word
  always_ff @(posedge clk) begin
    if (!rstN) begin
      enableMask  <= '0;
      defaultAddr <= '0;
    end else begin
      if (stb.enSet) enableMask <= enableMask | wrData[NUM_SRC-1:0];
      if (stb.enClr) enableMask <= enableMask & ~wrData[NUM_SRC-1:0];
      if (stb.defWr) defaultAddr <= wrData;
    end
  end

  assign status = irqReq & enableMask;
  assign irq    = |status;

  // Per-slot storage and eligibility
  for (genvar s = 0; s < NUM_SLOT; s++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rstN) begin
        slotAddr[s] <= '0;
        slotSrc[s]  <= '0;
        slotEn[s]   <= 1'b0;
      end else begin
        if (stb.slotAddrWr && int'(slotIdx) == s) slotAddr[s] <= wrData;
        if (stb.slotCtlWr && int'(slotIdx) == s) begin
          slotSrc[s] <= wrData[SRC_W-1:0];
          slotEn[s]  <= wrData[SRC_W];
        end
      end
    end
    assign candidate[s] = slotEn[s] && status[slotSrc[s]] && allowMask[s];
  end

  // Fixed priority: lowest slot index wins
  always_comb begin
    winIdx = '0;
    for (int i = NUM_SLOT - 1; i >= 0; i--) begin
      if (candidate[i]) winIdx = SLOT_W'(i);
    end
  end
  assign winValid = |candidate;

  always_comb begin
    case (rdSel)
      SEL_STATUS:   rdData = DATA_W'(status);
      SEL_ENABLE:   rdData = DATA_W'(enableMask);
      SEL_VECTOR:   rdData = winValid ? slotAddr[winIdx] : defaultAddr;
      SEL_DEFAULT:  rdData = defaultAddr;
      SEL_SLOTADDR: rdData = slotAddr[slotIdx];
      SEL_SLOTCTL:  rdData = DATA_W'({slotEn[slotIdx], slotSrc[slotIdx]});
      default:      rdData = '0;
    endcase
  end

  // R2: set-write raises the one bits and keeps the rest
  p_enable_set_r2: assert property (@(posedge clk) disable iff (!rstN)
    stb.enSet |=> ((enableMask & $past(wrData[NUM_SRC-1:0])) == $past(wrData[NUM_SRC-1:0]))
              && ((enableMask & ~$past(wrData[NUM_SRC-1:0]))
                  == ($past(enableMask) & ~$past(wrData[NUM_SRC-1:0]))));

  // R3: clear-write drops the one bits and keeps the rest
  p_enable_clr_r3: assert property (@(posedge clk) disable iff (!rstN)
    stb.enClr |=> ((enableMask & $past(wrData[NUM_SRC-1:0])) == '0)
              && ((enableMask & ~$past(wrData[NUM_SRC-1:0]))
                  == ($past(enableMask) & ~$past(wrData[NUM_SRC-1:0]))));

  // R8: a winner's source is enabled, requesting, and its slot is allowed
  p_winner_legal_r8: assert property (@(posedge clk) disable iff (!rstN)
    winValid |-> slotEn[winIdx] && enableMask[slotSrc[winIdx]]
                 && irqReq[slotSrc[winIdx]] && allowMask[winIdx]);

  // R4: no winner can exist while the IRQ line is low
  p_quiet_no_winner_r4: assert property (@(posedge clk) disable iff (!rstN)
    !irq |-> !winValid);

endmodule

// File: rtl/vic_top.sv
module vic_top
  import vic_pkg::*;
#(
  parameter int NUM_SRC  = 32,
  parameter int NUM_SLOT = 16,
  parameter int DATA_W   = 32,
  parameter int ADDR_W   = 12,
  localparam int SLOT_W  = $clog2(NUM_SLOT)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] irqReq,
  input  logic               regWrEn,
  input  logic               regRdEn,
  input  logic [ADDR_W-1:0]  regAddr,
  input  logic [DATA_W-1:0]  regWrData,
  output logic [DATA_W-1:0]  regRdData,
  output logic               irq
);

  strobes_t            stb;
  rdSel_e              rdSel;
  logic [SLOT_W-1:0]   slotIdx;
  logic [SLOT_W-1:0]   winIdx;
  logic                winValid;
  logic [NUM_SLOT-1:0] allowMask;

  vic_ctrl #(.NUM_SLOT(NUM_SLOT), .ADDR_W(ADDR_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regRdEn(regRdEn),
    .regAddr(regAddr), .winValid(winValid), .winIdx(winIdx),
    .stb(stb), .rdSel(rdSel), .slotIdx(slotIdx), .allowMask(allowMask)
  );

  vic_datapath #(.NUM_SRC(NUM_SRC), .NUM_SLOT(NUM_SLOT), .DATA_W(DATA_W)) dp_i (
    .clk(clk), .rstN(rstN), .irqReq(irqReq), .stb(stb), .rdSel(rdSel),
    .slotIdx(slotIdx), .wrData(regWrData), .allowMask(allowMask),
    .winValid(winValid), .winIdx(winIdx), .rdData(regRdData), .irq(irq)
  );

endmodule

// File: tb/vic_top_tb_top.sv
module vic_top_tb_top;

  localparam int CLK_P = 10;
  localparam logic [11:0] A_STATUS  = 12'h000;
  localparam logic [11:0] A_ENABLE  = 12'h004;
  localparam logic [11:0] A_ENCLR   = 12'h008;
  localparam logic [11:0] A_VECTOR  = 12'h00C;
  localparam logic [11:0] A_DEFAULT = 12'h010;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] irqReq = '0;
  logic        regWrEn = 1'b0;
  logic        regRdEn = 1'b0;
  logic [11:0] regAddr = '0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic        irq;

  always #(CLK_P/2) clk = ~clk;

  vic_top dut_i (
    .clk(clk), .rstN(rstN), .irqReq(irqReq), .regWrEn(regWrEn),
    .regRdEn(regRdEn), .regAddr(regAddr), .regWrData(regWrData),
    .regRdData(regRdData), .irq(irq)
  );

  typedef struct {
    logic [31:0] val;
    string       tag;
  } expItem_t;

  expItem_t expQ[$];
  int nCmp = 0;
  int nBad = 0;
  bit finished = 1'b0;

  function automatic logic [11:0] slotA(input int n);
    return 12'h100 + 12'(4 * n);
  endfunction
  function automatic logic [11:0] slotC(input int n);
    return 12'h200 + 12'(4 * n);
  endfunction

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk); regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk); regWrEn = 1'b0;
  endtask

  // Write and change the request inputs in the same cycle
  task automatic wrWithReq(input logic [11:0] a, input logic [31:0] d, input logic [31:0] r);
    @(negedge clk); regWrEn = 1'b1; regAddr = a; regWrData = d; irqReq = r;
    @(negedge clk); regWrEn = 1'b0;
  endtask

  // Driver: queue the expected value, then issue the read
  task automatic rd(input logic [11:0] a, input logic [31:0] e, input string tag);
    expQ.push_back('{val: e, tag: tag});
    @(negedge clk); regRdEn = 1'b1; regAddr = a;
    @(negedge clk); regRdEn = 1'b0;
  endtask

  task automatic setReq(input logic [31:0] r);
    @(negedge clk); irqReq = r;
  endtask

  task automatic checkIrq(input logic e, input string tag);
    @(negedge clk); #(CLK_P/4);
    nCmp++;
    if (irq !== e) begin
      nBad++;
      $display("FAIL %s: irq got %b expected %b", tag, irq, e);
    end
  endtask

  // Monitor: compare read data against the queued expectation
  initial begin
    forever begin
      @(negedge clk); #(CLK_P/4);
      if (regRdEn) begin
        expItem_t e;
        nCmp++;
        if (expQ.size() == 0) begin
          nBad++;
          $display("FAIL unexpected read: got %h expected none", regRdData);
        end else begin
          e = expQ.pop_front();
          if (regRdData !== e.val) begin
            nBad++;
            $display("FAIL %s: got %h expected %h", e.tag, regRdData, e.val);
          end
        end
      end
    end
  end

  initial begin
    #(CLK_P * 50000);
    if (!finished) begin
      nCmp++; nBad++;
      $display("FAIL watchdog (all requirements): got hang expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    rd(A_STATUS, 32'h0, "R1 status");
    rd(A_ENABLE, 32'h0, "R1 enable");
    rd(A_VECTOR, 32'h0, "R1 vector/default");
    rd(slotC(3), 32'h0, "R1 slot ctl");
    rd(slotA(3), 32'h0, "R1 slot addr");
    checkIrq(1'b0, "R1 irq");

    // R7 default word
    wr(A_DEFAULT, 32'hFFFF_FFFF);
    rd(A_DEFAULT, 32'hFFFF_FFFF, "R7 default readback");
    rd(A_VECTOR, 32'hFFFF_FFFF, "R7 vector idle");

    // R2 / R3 enable set and clear
    wr(A_ENABLE, 32'h0000_00F0);
    wr(A_ENABLE, 32'h0000_0101);
    rd(A_ENABLE, 32'h0000_01F1, "R2 enable set");
    wr(A_ENCLR, 32'h0000_0011);
    rd(A_ENABLE, 32'h0000_01E0, "R3 enable clear");

    // R4 status and irq
    setReq(32'h0000_0120);
    rd(A_STATUS, 32'h0000_0120, "R4 status");
    checkIrq(1'b1, "R4 irq high");
    setReq(32'h0000_0001);
    rd(A_STATUS, 32'h0, "R4 status masked");
    checkIrq(1'b0, "R4 irq low");

    // R5 slot programming
    wr(slotC(2), 32'hFFFF_FFE8);
    rd(slotC(2), 32'h0000_0028, "R5 ctl readback");
    wr(slotA(2), 32'hA000_0002);
    wr(slotC(5), 32'h25); wr(slotA(5), 32'hA000_0005);
    wr(slotC(7), 32'h27); wr(slotA(7), 32'hA000_0007);
    wr(slotC(0), 32'h29); wr(slotA(0), 32'hA000_0000);
    wr(slotC(9), 32'h08); wr(slotA(9), 32'hA000_0009);
    rd(slotA(5), 32'hA000_0005, "R5 addr readback");
    rd(slotC(9), 32'h0000_0008, "R5 ctl enable off");

    // R8 slot 0 source 9 not enabled
    setReq(32'h0000_0300);
    rd(A_VECTOR, 32'hA000_0002, "R8 disabled source skipped");
    wr(A_VECTOR, 32'h0);

    // R6 priority, R9 hold-off, R10 retire
    setReq(32'h0000_01A0);
    rd(A_VECTOR, 32'hA000_0002, "R6 highest slot wins");
    rd(A_VECTOR, 32'hFFFF_FFFF, "R9 same and lower held off");
    wr(A_VECTOR, 32'h1234_5678);
    rd(A_VECTOR, 32'hA000_0002, "R10 ack releases");
    wr(A_VECTOR, 32'h0);

    // R9 preemption, R11 nesting
    setReq(32'h0000_00A0);
    rd(A_VECTOR, 32'hA000_0005, "R6 slot 5");
    setReq(32'h0000_01A0);
    rd(A_VECTOR, 32'hA000_0002, "R9 higher preempts");
    rd(A_VECTOR, 32'hFFFF_FFFF, "R9 nested hold-off");
    setReq(32'h0000_00A0);
    wr(A_VECTOR, 32'h0);
    rd(A_VECTOR, 32'hFFFF_FFFF, "R11 outer level kept");
    wr(A_VECTOR, 32'h0);
    rd(A_VECTOR, 32'hA000_0005, "R11 outer retired");
    wr(A_VECTOR, 32'h0);
    wr(A_VECTOR, 32'h0);
    rd(A_VECTOR, 32'hA000_0005, "R10 ack idle no effect");

    // Retire and new higher request in one cycle
    wrWithReq(A_VECTOR, 32'h0, 32'h0000_01A0);
    rd(A_VECTOR, 32'hA000_0002, "R10 ack with new request");
    wr(A_VECTOR, 32'h0);

    // R8 after clearing source 8
    wr(A_ENCLR, 32'h0000_0100);
    rd(A_VECTOR, 32'hA000_0005, "R8 cleared source skipped");
    wr(A_VECTOR, 32'h0);
    rd(A_STATUS, 32'h0000_00A0, "R4 status after clear");
    checkIrq(1'b1, "R4 irq still high");

    // R2 / R3 zero writes
    wr(A_ENABLE, 32'h0);
    rd(A_ENABLE, 32'h0000_00E0, "R2 zero write");
    wr(A_ENCLR, 32'h0);
    rd(A_ENABLE, 32'h0000_00E0, "R3 zero write");

    setReq(32'h0);
    checkIrq(1'b0, "R4 irq idle");

    repeat (4) @(negedge clk);
    if (expQ.size() != 0) begin
      nCmp++; nBad++;
      $display("FAIL reads pending: got %0d expected 0", expQ.size());
    end
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end

endmodule